// File: doc/BRIEF.md
# Instruction TLB Access Gate

This block sits in the fetch stage beside a small tagless instruction cache and decides, one fetch ahead, whether the instruction TLB has to be powered for the next fetch. For every fetch the front end presents the current instruction address (word address), a flag saying the next fetch is a guaranteed hit in the small cache, the kind of the next fetch, the target field of a direct jump and the page of the top return-stack entry. The block answers with a registered TLB enable for the following fetch. It also gives the physical page number to use: the TLB's answer when the TLB is enabled, otherwise the page number it captured at the last lookup.

The core is a two-state machine that tracks whether the captured page number still belongs to the page being fetched. `PG_UNKNOWN` is the reset state. Any fetch that uses the TLB moves it to `PG_KNOWN`. A fetch that arrives in a new virtual page without a lookup (a guaranteed hit across a page boundary) moves it back to `PG_UNKNOWN`. Stored guarantees let a miss skip the lookup while the state is `PG_KNOWN`. A last-line-in-page flag covers sequential fetches. A same-page flag per cached instruction covers taken direct branches. Jumps and returns are settled by a compare at the start of the cycle.

Top module: `itlb_gate`

## Requirements
- R1: When the next fetch is flagged as a guaranteed small-cache hit and its kind is not other-indirect, the TLB is disabled for that next fetch.
- R2: Every fetch that has the TLB enabled captures `tlb_ppn` into the stored page register and enters `PG_KNOWN`.
- R3: A fetch made without a lookup whose virtual page (address bits above the low 10) differs from that of the previous fetch enters `PG_UNKNOWN`. A following fetch that is not a guaranteed hit then has the TLB enabled.
- R4: While the TLB is disabled, `phys_ppn` equals the page number captured at the most recent lookup. A miss may bypass the TLB only in `PG_KNOWN`.
- R5: When a cache line is filled at the last index (fill line position with its low 4 bits all ones), the last-line-in-page flag takes the value "all 8 bits of the fill line position are ones". A fill in the same cycle is forwarded to that cycle's decision.
- R6: With next kind sequential (code 0) on a miss, the TLB is enabled only if the last-line-in-page flag is set and the low 6 address bits (cache index plus word-in-line) are all ones.
- R7: With next kind direct jump (code 1) on a miss, the TLB is disabled when bits 25:10 of the 26-bit target field equal bits 25:10 of the current address, and enabled otherwise. The same-page flag of the jump's slot records the outcome.
- R8: With next kind direct branch (code 2) on a miss, the TLB is enabled unless the same-page flag of the branch's slot (low 6 address bits) is set. That flag is written on the next fetch: set if its virtual page equals the branch's, cleared otherwise.
- R9: With next kind return (code 3) on a miss, the TLB is disabled when `ras_vpn` equals the current virtual page, and enabled otherwise.
- R10: With next kind other-indirect (code 4), the TLB is enabled for the next fetch even when a hit is flagged.
- R11: After reset the first fetch has the TLB enabled, and the machine starts in `PG_UNKNOWN` with all flags clear.
- R12: A line fill clears the same-page flags of the four slots of the filled index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetch takes place this cycle |
| pc | input | 30 | Word address of the current instruction |
| next_hit | input | 1 | Next fetch is a guaranteed small-cache hit |
| next_kind | input | 3 | Kind of next fetch: 0 seq, 1 jump, 2 branch, 3 return, 4 indirect |
| jmp_field | input | 26 | Target field of a direct jump or call |
| ras_vpn | input | 20 | Virtual page of the top return-stack entry |
| fill_valid | input | 1 | A line is written into the small cache this cycle |
| fill_pos | input | 8 | Position of the filled line within its page (low 4 bits are the index) |
| tlb_ppn | input | 20 | Page number returned by the TLB |
| tlb_en | output | 1 | TLB enable for the current fetch |
| phys_ppn | output | 20 | Physical page number to use for the current fetch |

## Verification
Each decision is made during one fetch and shows up on `tlb_en` during the next fetch, exactly one cycle later, because it passes through a single register. The bench drives a fetch just after a falling edge and samples `tlb_en` and `phys_ppn` 1 ns later, so every check sees the decision from the previous fetch. Flag writes (fills, same-page updates, the page state) land at the rising edge after their fetch, so their effect is checked through the decision made one fetch later and seen two fetches after the stimulus. A fill at the last index is the exception: it is forwarded and acts within the same fetch.

// File: rtl/itlb_gate_pkg.sv
package itlb_gate_pkg;

    typedef enum logic [2:0] {
        FK_SEQ  = 3'd0,
        FK_DJMP = 3'd1,
        FK_DBR  = 3'd2,
        FK_RET  = 3'd3,
        FK_IND  = 3'd4
    } fetch_kind_e;

    typedef enum logic {
        PG_UNKNOWN = 1'b0,
        PG_KNOWN   = 1'b1
    } pg_state_e;

endpackage

// File: rtl/itlb_gate_flags.sv
module itlb_gate_flags #(
    parameter int IDX_W      = 4,
    parameter int OFF_W      = 2,
    parameter int POS_W      = 8,
    localparam int SLOT_W    = IDX_W + OFF_W,
    localparam int N_INST    = 1 << SLOT_W,
    localparam int LINE_INST = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [POS_W-1:0]  fill_pos,
    input  logic              br_upd,
    input  logic [SLOT_W-1:0] br_slot,
    input  logic              br_val,
    input  logic              jmp_upd,
    input  logic [SLOT_W-1:0] jmp_slot,
    input  logic              jmp_val,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              sp_rd,
    output logic              llp_eff
);

    logic              llp_q;
    logic [N_INST-1:0] sp_q;
    logic              fill_last_idx;

    assign fill_last_idx = fill_valid && (&fill_pos[IDX_W-1:0]);
    assign llp_eff       = fill_last_idx ? (&fill_pos) : llp_q;
    assign sp_rd         = sp_q[rd_slot];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            llp_q <= 1'b0;
        else if (fill_last_idx)
            llp_q <= &fill_pos;
    end

    for (genvar s = 0; s < N_INST; s++) begin : g_sp
        localparam logic [IDX_W-1:0] LINE_IDX = IDX_W'(s / LINE_INST);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sp_q[s] <= 1'b0;
            else if (jmp_upd && jmp_slot == SLOT_W'(s))
                sp_q[s] <= jmp_val;
            else if (br_upd && br_slot == SLOT_W'(s))
                sp_q[s] <= br_val;
            else if (fill_valid && fill_pos[IDX_W-1:0] == LINE_IDX)
                sp_q[s] <= 1'b0;
        end
    end

endmodule

// File: rtl/itlb_gate_decide.sv
module itlb_gate_decide
    import itlb_gate_pkg::*;
#(
    parameter int PC_W       = 30,
    parameter int JF_W       = 26,
    parameter int PAGE_OFF_W = 10,
    parameter int SLOT_W     = 6,
    localparam int VPN_W     = PC_W - PAGE_OFF_W
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             next_hit,
    input  fetch_kind_e      kind,
    input  logic [JF_W-1:0]  jmp_field,
    input  logic [VPN_W-1:0] ras_vpn,
    input  logic             cp_eff,
    input  logic             llp_eff,
    input  logic             sp_cur,
    output logic             need_tlb,
    output logic             jmp_same
);

    assign jmp_same = (jmp_field[JF_W-1:PAGE_OFF_W] == pc[JF_W-1:PAGE_OFF_W]);

    always_comb begin
        need_tlb = 1'b1;
        if (kind == FK_IND)
            need_tlb = 1'b1;
        else if (next_hit)
            need_tlb = 1'b0;
        else if (!cp_eff)
            need_tlb = 1'b1;
        else begin
            unique case (kind)
                FK_SEQ:  need_tlb = llp_eff && (&pc[SLOT_W-1:0]);
                FK_DJMP: need_tlb = !jmp_same;
                FK_DBR:  need_tlb = !sp_cur;
                FK_RET:  need_tlb = (ras_vpn != pc[PC_W-1:PAGE_OFF_W]);
                default: need_tlb = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/itlb_gate.sv
module itlb_gate
    import itlb_gate_pkg::*;
#(
    parameter int PC_W       = 30,
    parameter int JF_W       = 26,
    parameter int PAGE_OFF_W = 10,
    parameter int IDX_W      = 4,
    parameter int OFF_W      = 2,
    parameter int PPN_W      = 20,
    localparam int VPN_W     = PC_W - PAGE_OFF_W,
    localparam int SLOT_W    = IDX_W + OFF_W,
    localparam int POS_W     = PAGE_OFF_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   pc,
    input  logic              next_hit,
    input  logic [2:0]        next_kind,
    input  logic [JF_W-1:0]   jmp_field,
    input  logic [VPN_W-1:0]  ras_vpn,
    input  logic              fill_valid,
    input  logic [POS_W-1:0]  fill_pos,
    input  logic [PPN_W-1:0]  tlb_ppn,
    output logic              tlb_en,
    output logic [PPN_W-1:0]  phys_ppn
);

    pg_state_e         pg_state, pg_next;
    fetch_kind_e       kind;
    logic              tlb_en_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [VPN_W-1:0]  cur_vpn, prev_vpn;
    logic              prev_valid;
    logic              crossed, cp_eff;
    logic              pend_br;
    logic [SLOT_W-1:0] pend_slot;
    logic              sp_cur, llp_eff, need_tlb, jmp_same;

    assign kind    = fetch_kind_e'(next_kind);
    assign cur_vpn = pc[PC_W-1:PAGE_OFF_W];
    assign crossed = prev_valid && (cur_vpn != prev_vpn);
    assign cp_eff  = tlb_en_q || (!crossed && pg_state == PG_KNOWN);

    // Page state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pg_state <= PG_UNKNOWN;
        else
            pg_state <= pg_next;
    end

    // Page state transitions
    always_comb begin
        pg_next = pg_state;
        if (fetch_valid) begin
            unique case (pg_state)
                PG_UNKNOWN: if (tlb_en_q) pg_next = PG_KNOWN;
                PG_KNOWN:   if (!tlb_en_q && crossed) pg_next = PG_UNKNOWN;
                default:    pg_next = PG_UNKNOWN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlb_en_q   <= 1'b1;
            ppn_q      <= '0;
            prev_vpn   <= '0;
            prev_valid <= 1'b0;
            pend_br    <= 1'b0;
            pend_slot  <= '0;
        end else if (fetch_valid) begin
            tlb_en_q   <= need_tlb;
            if (tlb_en_q)
                ppn_q <= tlb_ppn;
            prev_vpn   <= cur_vpn;
            prev_valid <= 1'b1;
            pend_br    <= (kind == FK_DBR);
            pend_slot  <= pc[SLOT_W-1:0];
        end
    end

    assign tlb_en   = fetch_valid && tlb_en_q;
    assign phys_ppn = tlb_en_q ? tlb_ppn : ppn_q;

    itlb_gate_flags #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W),
        .POS_W (POS_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_pos   (fill_pos),
        .br_upd     (fetch_valid && pend_br),
        .br_slot    (pend_slot),
        .br_val     (!crossed),
        .jmp_upd    (fetch_valid && kind == FK_DJMP),
        .jmp_slot   (pc[SLOT_W-1:0]),
        .jmp_val    (jmp_same),
        .rd_slot    (pc[SLOT_W-1:0]),
        .sp_rd      (sp_cur),
        .llp_eff    (llp_eff)
    );

    itlb_gate_decide #(
        .PC_W       (PC_W),
        .JF_W       (JF_W),
        .PAGE_OFF_W (PAGE_OFF_W),
        .SLOT_W     (SLOT_W)
    ) u_decide (
        .pc        (pc),
        .next_hit  (next_hit),
        .kind      (kind),
        .jmp_field (jmp_field),
        .ras_vpn   (ras_vpn),
        .cp_eff    (cp_eff),
        .llp_eff   (llp_eff),
        .sp_cur    (sp_cur),
        .need_tlb  (need_tlb),
        .jmp_same  (jmp_same)
    );

endmodule

// File: rtl/itlb_gate_chk.sv
module itlb_gate_chk #(
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             next_hit,
    input logic [2:0]       next_kind,
    input logic             tlb_en_q,
    input logic             cp_eff,
    input logic             pg_known,
    input logic [PPN_W-1:0] ppn_q
);

    // R1
    hit_skips_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && next_hit && next_kind != 3'd4) |=> !tlb_en_q);

    // R2
    lookup_sets_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && tlb_en_q) |=> pg_known);

    // R3
    unknown_forces_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !next_hit && !cp_eff) |=> tlb_en_q);

    // R4
    bypass_keeps_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !tlb_en_q) |=> (ppn_q == $past(ppn_q)));

    // R10
    indirect_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && next_kind == 3'd4) |=> tlb_en_q);

endmodule

bind itlb_gate itlb_gate_chk #(.PPN_W(PPN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .next_hit    (next_hit),
    .next_kind   (next_kind),
    .tlb_en_q    (tlb_en_q),
    .cp_eff      (cp_eff),
    .pg_known    (pg_state == itlb_gate_pkg::PG_KNOWN),
    .ppn_q       (ppn_q)
);

// File: tb/itlb_gate_bench.sv
module itlb_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [29:0] pc = '0;
    logic        next_hit = 1'b0;
    logic [2:0]  next_kind = 3'd0;
    logic [25:0] jmp_field = '0;
    logic [19:0] ras_vpn = '0;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_pos = '0;
    logic [19:0] tlb_ppn;
    logic        tlb_en;
    logic [19:0] phys_ppn;

    int n_checks = 0;
    int n_fail = 0;
    logic [19:0] last_ppn = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // The modelled TLB: any fixed mapping the bench can predict
    assign tlb_ppn = pc[29:10] ^ 20'h5A5A5;

    itlb_gate u_itlb_gate (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pc(pc),
        .next_hit(next_hit), .next_kind(next_kind), .jmp_field(jmp_field),
        .ras_vpn(ras_vpn), .fill_valid(fill_valid), .fill_pos(fill_pos),
        .tlb_ppn(tlb_ppn), .tlb_en(tlb_en), .phys_ppn(phys_ppn)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One fetch: drive after a falling edge, sample 1 ns later
    task automatic fetch(input logic [29:0] a, input logic hit, input logic [2:0] k,
                         input logic [25:0] jf, input logic [19:0] rv,
                         input logic fv, input logic [7:0] fp,
                         input logic exp_en, input string req);
        @(negedge clk);
        fetch_valid = 1'b1; pc = a; next_hit = hit; next_kind = k;
        jmp_field = jf; ras_vpn = rv; fill_valid = fv; fill_pos = fp;
        #1;
        check(req, {31'd0, tlb_en}, {31'd0, exp_en});
        if (exp_en)
            last_ppn = a[29:10] ^ 20'h5A5A5;
        else
            check({req, " ppn"}, {12'd0, phys_ppn}, {12'd0, last_ppn});
    endtask

    task automatic t_reset;
        // R11: first fetch after reset looks up
        fetch(30'h400, 0, 3'd0, 0, 0, 0, 0, 1'b1, "R11");
        // R2 then R6: captured page reused on a sequential miss
        fetch(30'h401, 0, 3'd0, 0, 0, 0, 0, 1'b0, "R6");
    endtask

    task automatic t_llp;
        // R5: last-index fill not at page end clears the flag
        fetch(30'h43F, 0, 3'd0, 0, 0, 1, 8'h0F, 1'b0, "R6");
        // R5: last-index fill at page end sets it, forwarded
        fetch(30'h7FF, 0, 3'd0, 0, 0, 1, 8'hFF, 1'b0, "R5");
        fetch(30'h800, 1, 3'd0, 0, 0, 0, 0, 1'b1, "R5");
    endtask

    task automatic t_hit_cross;
        fetch(30'h801, 1, 3'd2, 0, 0, 0, 0, 1'b0, "R1");
        // lands on a new page without lookup: R3
        fetch(30'hC00, 0, 3'd0, 0, 0, 0, 0, 1'b0, "R1");
        fetch(30'hC01, 0, 3'd0, 0, 0, 0, 0, 1'b1, "R3");
    endtask

    task automatic t_branch;
        fetch(30'hC02, 0, 3'd2, 0, 0, 0, 0, 1'b0, "R4");
        fetch(30'hC20, 0, 3'd0, 0, 0, 0, 0, 1'b1, "R8");
        fetch(30'hC02, 0, 3'd2, 0, 0, 0, 0, 1'b0, "R8");
        fetch(30'hC20, 0, 3'd1, 26'h000C05, 0, 0, 0, 1'b0, "R8");
    endtask

    task automatic t_jump;
        fetch(30'hC05, 0, 3'd1, 26'h001405, 0, 0, 0, 1'b0, "R7");
        fetch(30'h1405, 0, 3'd3, 0, 20'h5, 0, 0, 1'b1, "R7");
    endtask

    task automatic t_return;
        fetch(30'h1406, 0, 3'd3, 0, 20'h7, 0, 0, 1'b0, "R9");
        fetch(30'h1C00, 1, 3'd4, 0, 0, 0, 0, 1'b1, "R9");
    endtask

    task automatic t_indirect;
        // hit flagged but indirect: R10; also fill index 0 for R12
        fetch(30'h1C01, 0, 3'd0, 0, 0, 1, 8'h00, 1'b1, "R10");
    endtask

    task automatic t_evict;
        fetch(30'h1C02, 0, 3'd2, 0, 0, 0, 0, 1'b0, "R6");
        fetch(30'h1C40, 0, 3'd0, 0, 0, 0, 0, 1'b1, "R12");
        fetch(30'h1C02, 0, 3'd2, 0, 0, 0, 0, 1'b0, "R6");
        fetch(30'h1C40, 0, 3'd0, 0, 0, 0, 0, 1'b0, "R8");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset", {31'd0, tlb_en}, 32'd0);
        rst_n = 1'b1;
        t_reset();
        t_llp();
        t_hit_cross();
        t_branch();
        t_jump();
        t_return();
        t_indirect();
        t_evict();
        @(negedge clk);
        fetch_valid = 1'b0;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule